// File: doc/BRIEF.md
# Packed-RGB Pixel Bridge

This bridge sits between a 64-bit graphics bus master and a 64-bit RAM port. On the bus side, one beat carries two 32-bit pixels, and each pixel has its own alpha byte. In RAM, pixels are kept as back-to-back 3-byte RGB triples with no padding. When depth conversion is on, the bridge does three things:

- It rescales the bus address, measured from a window start, into a packed byte offset measured from a RAM base.
- On writes, it drops the alpha bytes and places the six colour bytes with matching write enables.
- On reads, it rebuilds the two 32-bit pixels and inserts a programmable constant as alpha.

Six packed bytes can cross a 64-bit RAM word boundary. In that case, one bus beat becomes two RAM accesses. When conversion is off, each beat goes to RAM unchanged.

Every interface that carries data uses valid/ready:

- **Bus request:** accepted only while the bridge is idle.
- **RAM request:** once raised, valid holds and all request fields stay stable until ready is seen.
- **Bus response:** held with stable data until the master raises ready. One response is returned per accepted request; a write response carries zero data.
- **RAM read data:** returns on `ram_rsp_valid` at least one cycle after the read is accepted, and has no back-pressure.

The configuration pins are plain levels. They must stay constant while a transfer is in progress.

Top module: `gfx_pix_bridge`

## Requirements
- R1: After reset, `bus_req_ready` is 1 and both `bus_rsp_valid` and `ram_req_valid` are 0.
- R2: With `cfg_mode[1]`=1, the first RAM access goes to the 8-byte-aligned word containing byte `cfg_base + (bus_req_addr - cfg_first)*3/4`. The bus address must be 8-byte aligned.
- R3: On a converted write, no alpha byte reaches RAM. Every RAM byte outside the six packed positions of the beat is left unchanged.
- R4: `cfg_mode[0]` sets the alpha position inside each pixel. With 0, alpha is byte 3 of the pixel and R,G,B are bytes 0,1,2. With 1, alpha is byte 0 and R,G,B are bytes 1,2,3. Pixel 0 occupies bus bytes 0-3 and pixel 1 occupies bytes 4-7. In RAM, pixel 0's RGB comes first, then pixel 1's.
- R5: When the packed start lane within the word is greater than 2, the bridge issues exactly two RAM accesses: first the lower word, then the word 8 bytes above it. Otherwise it issues exactly one.
- R6: A converted write enables only those packed bytes whose source bus byte strobe is high. A pixel with all three colour strobes low writes nothing.
- R7: On a converted read, each returned pixel carries its RGB from the packed RAM bytes and `cfg_alpha` in its alpha byte. Reads that span two words are merged before the response.
- R8: With `cfg_mode[1]`=0, the bridge makes one RAM access at the bus address, with the bus data and strobes unchanged. Read data is returned unchanged.
- R9: The bridge accepts a new bus request only while idle. A raised RAM request keeps its valid and all its fields stable until accepted.
- R10: A raised bus response keeps its valid and data stable until `bus_rsp_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | Bit 1: conversion enable; bit 0: alpha is first byte |
| cfg_first | input | ADDR_W | Bus window start address |
| cfg_base | input | ADDR_W | Packed RAM base address |
| cfg_alpha | input | 8 | Alpha constant inserted on reads |
| bus_req_valid | input | 1 | Bus request valid |
| bus_req_ready | output | 1 | Bridge can accept a request |
| bus_req_write | input | 1 | 1 = write, 0 = read |
| bus_req_addr | input | ADDR_W | Beat address, 8-byte aligned |
| bus_req_wdata | input | 64 | Two 32-bit pixels |
| bus_req_wstrb | input | 8 | Byte strobes for write data |
| bus_rsp_valid | output | 1 | Response valid |
| bus_rsp_ready | input | 1 | Master accepts response |
| bus_rsp_rdata | output | 64 | Read data (zero for writes) |
| ram_req_valid | output | 1 | RAM request valid |
| ram_req_ready | input | 1 | RAM accepts request |
| ram_req_write | output | 1 | RAM write |
| ram_req_addr | output | ADDR_W | RAM word address |
| ram_req_wdata | output | 64 | RAM write data |
| ram_req_wstrb | output | 8 | RAM byte enables |
| ram_rsp_valid | input | 1 | RAM read data valid |
| ram_rsp_rdata | input | 64 | RAM read data |

## Verification
The assertions rely on the following properties of the inputs:

- The RAM returns exactly one data beat per accepted read, and only while a read is outstanding.
- The master keeps request fields meaningful only while valid is raised.
- Configuration does not change during a transfer.

The stimulus meets these properties:

- A bench RAM model answers each read one cycle after acceptance and stalls its ready from a pseudo-random pattern.
- The master side raises one request at a time, on aligned addresses, and applies random response back-pressure.
- Configuration is changed only between transfers.

// File: rtl/gfx_pix_pkg.sv
package gfx_pix_pkg;
  localparam int BEAT_BYTES = 8;
  localparam int PIX_PER_BEAT = 2;
  localparam int BUS_PIX_BYTES = 4;
  localparam int RGB_BYTES = 3;
  localparam int PACK_BYTES = PIX_PER_BEAT * RGB_BYTES;
  localparam int DATA_W = BEAT_BYTES * 8;
  localparam int LANE_W = $clog2(BEAT_BYTES);
  localparam int WIDE_BYTES = 2 * BEAT_BYTES;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ0,
    ST_WAIT0,
    ST_REQ1,
    ST_WAIT1,
    ST_RSP
  } br_state_t;
endpackage

// File: rtl/gfx_addr_map.sv
module gfx_addr_map
  import gfx_pix_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] first,
  input  logic [ADDR_W-1:0] base,
  input  logic              conv,
  output logic [ADDR_W-1:0] word_addr,
  output logic [LANE_W-1:0] lane,
  output logic              span
);
  logic [ADDR_W-1:0] rel;
  logic [ADDR_W-1:0] packed_off;
  logic [ADDR_W-1:0] byte_addr;

  always_comb begin
    rel        = addr - first;
    // rel is a multiple of 4, so rel/2 + rel/4 is exactly rel*3/4
    packed_off = (rel >> 1) + (rel >> 2);
    byte_addr  = conv ? (base + packed_off) : addr;
    word_addr  = {byte_addr[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
    lane       = conv ? byte_addr[LANE_W-1:0] : '0;
    span       = conv && ({1'b0, lane} > (LANE_W+1)'(BEAT_BYTES - PACK_BYTES));
  end
endmodule

// File: rtl/gfx_pix_pack.sv
module gfx_pix_pack
  import gfx_pix_pkg::*;
(
  input  logic [DATA_W-1:0]       wdata,
  input  logic [BEAT_BYTES-1:0]   wstrb,
  input  logic                    alpha_first,
  input  logic [LANE_W-1:0]       lane,
  output logic [2*DATA_W-1:0]     wide_data,
  output logic [WIDE_BYTES-1:0]   wide_strb
);
  logic [PACK_BYTES*8-1:0] pk_data;
  logic [PACK_BYTES-1:0]   pk_strb;
  logic [LANE_W+2:0]       bit_shift;

  always_comb begin
    pk_data = '0;
    pk_strb = '0;
    for (int p = 0; p < PIX_PER_BEAT; p++) begin
      for (int c = 0; c < RGB_BYTES; c++) begin
        pk_data[(p*RGB_BYTES+c)*8 +: 8] =
          wdata[(p*BUS_PIX_BYTES + c + int'(alpha_first))*8 +: 8];
        pk_strb[p*RGB_BYTES+c] = wstrb[p*BUS_PIX_BYTES + c + int'(alpha_first)];
      end
    end
    bit_shift = {lane, 3'b000};
    wide_data = {{(2*DATA_W-PACK_BYTES*8){1'b0}}, pk_data} << bit_shift;
    wide_strb = {{(WIDE_BYTES-PACK_BYTES){1'b0}}, pk_strb} << lane;
  end
endmodule

// File: rtl/gfx_pix_unpack.sv
module gfx_pix_unpack
  import gfx_pix_pkg::*;
(
  input  logic [DATA_W-1:0] lo_word,
  input  logic [DATA_W-1:0] hi_word,
  input  logic [LANE_W-1:0] lane,
  input  logic              alpha_first,
  input  logic [7:0]        alpha,
  output logic [DATA_W-1:0] rdata
);
  logic [2*DATA_W-1:0] wide;
  logic [LANE_W+2:0]   bit_shift;

  always_comb begin
    bit_shift = {lane, 3'b000};
    wide  = {hi_word, lo_word} >> bit_shift;
    rdata = '0;
    for (int p = 0; p < PIX_PER_BEAT; p++) begin
      for (int c = 0; c < RGB_BYTES; c++) begin
        rdata[(p*BUS_PIX_BYTES + c + int'(alpha_first))*8 +: 8] =
          wide[(p*RGB_BYTES+c)*8 +: 8];
      end
      rdata[(p*BUS_PIX_BYTES + (alpha_first ? 0 : BUS_PIX_BYTES-1))*8 +: 8] = alpha;
    end
  end
endmodule

// File: rtl/gfx_pix_bridge.sv
module gfx_pix_bridge
  import gfx_pix_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            cfg_mode,
  input  logic [ADDR_W-1:0]     cfg_first,
  input  logic [ADDR_W-1:0]     cfg_base,
  input  logic [7:0]            cfg_alpha,
  input  logic                  bus_req_valid,
  output logic                  bus_req_ready,
  input  logic                  bus_req_write,
  input  logic [ADDR_W-1:0]     bus_req_addr,
  input  logic [DATA_W-1:0]     bus_req_wdata,
  input  logic [BEAT_BYTES-1:0] bus_req_wstrb,
  output logic                  bus_rsp_valid,
  input  logic                  bus_rsp_ready,
  output logic [DATA_W-1:0]     bus_rsp_rdata,
  output logic                  ram_req_valid,
  input  logic                  ram_req_ready,
  output logic                  ram_req_write,
  output logic [ADDR_W-1:0]     ram_req_addr,
  output logic [DATA_W-1:0]     ram_req_wdata,
  output logic [BEAT_BYTES-1:0] ram_req_wstrb,
  input  logic                  ram_rsp_valid,
  input  logic [DATA_W-1:0]     ram_rsp_rdata
);
  br_state_t state;
  logic                  r_write;
  logic [ADDR_W-1:0]     r_addr;
  logic [DATA_W-1:0]     r_wdata;
  logic [BEAT_BYTES-1:0] r_wstrb;
  logic [DATA_W-1:0]     r_lo, r_hi;

  logic                  conv, alpha_first;
  logic [ADDR_W-1:0]     word0;
  logic [LANE_W-1:0]     lane;
  logic                  span;
  logic [2*DATA_W-1:0]   wide_data;
  logic [WIDE_BYTES-1:0] wide_strb;
  logic [DATA_W-1:0]     conv_rdata;
  logic                  second;

  assign conv        = cfg_mode[1];
  assign alpha_first = cfg_mode[0];

  gfx_addr_map #(.ADDR_W(ADDR_W)) u_map (
    .addr(r_addr), .first(cfg_first), .base(cfg_base), .conv(conv),
    .word_addr(word0), .lane(lane), .span(span)
  );

  gfx_pix_pack u_pack (
    .wdata(r_wdata), .wstrb(r_wstrb), .alpha_first(alpha_first), .lane(lane),
    .wide_data(wide_data), .wide_strb(wide_strb)
  );

  gfx_pix_unpack u_unpack (
    .lo_word(r_lo), .hi_word(r_hi), .lane(lane), .alpha_first(alpha_first),
    .alpha(cfg_alpha), .rdata(conv_rdata)
  );

  assign second        = (state == ST_REQ1);
  assign bus_req_ready = (state == ST_IDLE);
  assign ram_req_valid = (state == ST_REQ0) || (state == ST_REQ1);
  assign ram_req_write = r_write;
  assign ram_req_addr  = second ? (word0 + ADDR_W'(BEAT_BYTES)) : word0;

  always_comb begin
    if (!conv) begin
      ram_req_wdata = r_wdata;
      ram_req_wstrb = r_wstrb;
    end else if (second) begin
      ram_req_wdata = wide_data[2*DATA_W-1:DATA_W];
      ram_req_wstrb = wide_strb[WIDE_BYTES-1:BEAT_BYTES];
    end else begin
      ram_req_wdata = wide_data[DATA_W-1:0];
      ram_req_wstrb = wide_strb[BEAT_BYTES-1:0];
    end
  end

  assign bus_rsp_valid = (state == ST_RSP);
  assign bus_rsp_rdata = r_write ? '0 : (conv ? conv_rdata : r_lo);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      r_write <= 1'b0;
      r_addr  <= '0;
      r_wdata <= '0;
      r_wstrb <= '0;
      r_lo    <= '0;
      r_hi    <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (bus_req_valid) begin
          r_write <= bus_req_write;
          r_addr  <= bus_req_addr;
          r_wdata <= bus_req_wdata;
          r_wstrb <= bus_req_wstrb;
          state   <= ST_REQ0;
        end
        ST_REQ0: if (ram_req_ready) begin
          if (!r_write)  state <= ST_WAIT0;
          else if (span) state <= ST_REQ1;
          else           state <= ST_RSP;
        end
        ST_WAIT0: if (ram_rsp_valid) begin
          r_lo  <= ram_rsp_rdata;
          state <= span ? ST_REQ1 : ST_RSP;
        end
        ST_REQ1: if (ram_req_ready) state <= r_write ? ST_RSP : ST_WAIT1;
        ST_WAIT1: if (ram_rsp_valid) begin
          r_hi  <= ram_rsp_rdata;
          state <= ST_RSP;
        end
        ST_RSP: if (bus_rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_ramreq_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_req_valid && !ram_req_ready) |=> (ram_req_valid && $stable(ram_req_addr)
      && $stable(ram_req_wdata) && $stable(ram_req_wstrb) && $stable(ram_req_write)));

  assert_accept_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && bus_req_ready) |=> !bus_req_ready);

  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rsp_valid && !bus_rsp_ready) |=> (bus_rsp_valid && $stable(bus_rsp_rdata)));

  assert_strobe_budget_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_req_valid && ram_req_write && conv) |-> ($countones(ram_req_wstrb) <= PACK_BYTES));
endmodule

// File: tb/tb_gfx_pix_bridge.sv
module tb_gfx_pix_bridge;
  localparam logic [31:0] FIRST = 32'h100;
  localparam logic [31:0] BASE  = 32'h40;

  logic clk = 0, rst_n = 0;
  logic [1:0]  cfg_mode = 2'b10;
  logic [31:0] cfg_first = FIRST, cfg_base = BASE;
  logic [7:0]  cfg_alpha = 8'h5A;
  logic bus_req_valid = 0, bus_req_write = 0, bus_rsp_ready = 0;
  logic [31:0] bus_req_addr = 0;
  logic [63:0] bus_req_wdata = 0;
  logic [7:0]  bus_req_wstrb = 0;
  logic bus_req_ready, bus_rsp_valid, ram_req_valid, ram_req_write;
  logic [63:0] bus_rsp_rdata, ram_req_wdata;
  logic [31:0] ram_req_addr;
  logic [7:0]  ram_req_wstrb;
  logic ram_req_ready = 0, ram_rsp_valid = 0;
  logic [63:0] ram_rsp_rdata = 0;

  gfx_pix_bridge dut (.*);

  always #4 clk = ~clk;

  int checks = 0, failures = 0;
  logic [7:0] mem [0:511];
  logic [7:0] refm [0:511];
  int acc_cnt = 0;
  logic in_xact = 0;
  logic [31:0] exp_w0;
  logic exp_span;
  logic [7:0] lfsr = 8'h1;

  task automatic fail(input string req, input logic [63:0] act, input logic [63:0] exp);
    failures++;
    $display("FAIL %s: actual=%h expected=%h", req, act, exp);
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) fail(req, act, exp);
  endtask

  // RAM model: one-cycle read latency, pseudo-random ready
  always @(posedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    ram_req_ready <= rst_n && (lfsr[0] | lfsr[2]);
    ram_rsp_valid <= 1'b0;
    if (rst_n && ram_req_valid && ram_req_ready) begin
      acc_cnt <= acc_cnt + 1;
      if (ram_req_write) begin
        for (int i = 0; i < 8; i++)
          if (ram_req_wstrb[i]) mem[ram_req_addr[8:0] + 9'(i)] <= ram_req_wdata[i*8 +: 8];
      end else begin
        ram_rsp_valid <= 1'b1;
        for (int i = 0; i < 8; i++) ram_rsp_rdata[i*8 +: 8] <= mem[ram_req_addr[8:0] + 9'(i)];
      end
    end
  end

  // per-clock monitor: address window and handshake stability
  logic p_rv = 0, p_rr = 0, p_bv = 0, p_br = 0;
  logic [31:0] p_ra;
  logic [63:0] p_rd, p_bd;
  always @(negedge clk) begin
    if (rst_n) begin
      if (in_xact && ram_req_valid) begin
        checks++;
        if (!(ram_req_addr == exp_w0 || (exp_span && ram_req_addr == exp_w0 + 8)))
          fail("R2 ram addr", {32'h0, ram_req_addr}, {32'h0, exp_w0});
      end
      if (p_rv && !p_rr) begin
        checks++;
        if (!ram_req_valid || ram_req_addr !== p_ra || ram_req_wdata !== p_rd)
          fail("R9 ram req hold", ram_req_wdata, p_rd);
      end
      if (p_bv && !p_br) begin
        checks++;
        if (!bus_rsp_valid || bus_rsp_rdata !== p_bd)
          fail("R10 rsp hold", bus_rsp_rdata, p_bd);
      end
    end
    p_rv = ram_req_valid; p_rr = ram_req_ready; p_ra = ram_req_addr; p_rd = ram_req_wdata;
    p_bv = bus_rsp_valid; p_bd = bus_rsp_rdata;
  end
  always @(posedge clk) p_br <= bus_rsp_ready;

  function automatic int byte_addr(input logic [31:0] a);
    if (cfg_mode[1]) return int'(BASE) + (int'(a - FIRST) * 3) / 4;
    return int'(a);
  endfunction

  function automatic int src_idx(input int p, input int c);
    return p * 4 + c + (cfg_mode[0] ? 1 : 0);
  endfunction

  task automatic ref_write(input logic [31:0] a, input logic [63:0] d, input logic [7:0] s);
    int b = byte_addr(a);
    if (cfg_mode[1]) begin
      for (int p = 0; p < 2; p++)
        for (int c = 0; c < 3; c++)
          if (s[src_idx(p, c)]) refm[b + p*3 + c] = d[src_idx(p, c)*8 +: 8];
    end else begin
      for (int i = 0; i < 8; i++) if (s[i]) refm[b + i] = d[i*8 +: 8];
    end
  endtask

  function automatic logic [63:0] ref_read(input logic [31:0] a);
    logic [63:0] r = '0;
    int b = byte_addr(a);
    if (cfg_mode[1]) begin
      for (int p = 0; p < 2; p++) begin
        for (int c = 0; c < 3; c++) r[src_idx(p, c)*8 +: 8] = refm[b + p*3 + c];
        r[(p*4 + (cfg_mode[0] ? 0 : 3))*8 +: 8] = cfg_alpha;
      end
    end else begin
      for (int i = 0; i < 8; i++) r[i*8 +: 8] = refm[b + i];
    end
    return r;
  endfunction

  task automatic xact(input logic wr, input logic [31:0] a, input logic [63:0] d,
                      input logic [7:0] s, output logic [63:0] r);
    int b = byte_addr(a);
    exp_w0 = 32'(b) & ~32'h7;
    exp_span = cfg_mode[1] && ((b % 8) > 2);
    @(negedge clk);
    acc_cnt = 0;
    in_xact = 1;
    bus_req_valid = 1; bus_req_write = wr; bus_req_addr = a;
    bus_req_wdata = d; bus_req_wstrb = s;
    while (!bus_req_ready) @(negedge clk);
    @(negedge clk);
    bus_req_valid = 0;
    forever begin
      if (bus_rsp_valid && ($urandom_range(0, 2) != 0)) begin
        bus_rsp_ready = 1;
        r = bus_rsp_rdata;
        @(negedge clk);
        bus_rsp_ready = 0;
        break;
      end
      @(negedge clk);
    end
    in_xact = 0;
    chk(exp_span ? "R5 two accesses" : "R5 one access", 64'(acc_cnt), exp_span ? 2 : 1);
  endtask

  task automatic wr_chk(input string req, input logic [31:0] a, input logic [63:0] d,
                        input logic [7:0] s);
    logic [63:0] r;
    int bad = -1;
    xact(1'b1, a, d, s, r);
    ref_write(a, d, s);
    for (int i = 0; i < 512; i++) if (mem[i] !== refm[i] && bad < 0) bad = i;
    checks++;
    if (bad >= 0) fail(req, {56'h0, mem[bad]}, {56'h0, refm[bad]});
    chk("R10 write rsp zero", r, 64'h0);
  endtask

  task automatic rd_chk(input string req, input logic [31:0] a);
    logic [63:0] r;
    xact(1'b0, a, 64'h0, 8'h0, r);
    chk(req, r, ref_read(a));
  endtask

  task automatic finish_up;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_up();
  end

  initial begin
    for (int i = 0; i < 512; i++) begin
      mem[i] = 8'(i * 7 + 3);
      refm[i] = 8'(i * 7 + 3);
    end
    repeat (3) @(negedge clk);
    chk("R1 req ready", {63'h0, bus_req_ready}, 1);
    chk("R1 rsp valid", {63'h0, bus_rsp_valid}, 0);
    chk("R1 ram valid", {63'h0, ram_req_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 ready after reset", {63'h0, bus_req_ready}, 1);

    // R2 R3 R5: alpha-last, all four lane phases
    cfg_mode = 2'b10;
    for (int k = 0; k < 8; k++)
      wr_chk("R3 converted write", FIRST + 32'(k*8), {8'hA0 + 8'(k), 24'hC0FFEE ^ 24'(k),
             8'hA8 + 8'(k), 24'h123456 + 24'(k*3)}, 8'hFF);
    for (int k = 0; k < 8; k++) rd_chk("R7 converted read", FIRST + 32'(k*8));
    cfg_alpha = 8'hE1;
    rd_chk("R7 new alpha", FIRST + 32'(3*8));

    // R4 alpha first
    cfg_mode = 2'b11;
    for (int k = 10; k < 14; k++)
      wr_chk("R4 alpha-first write", FIRST + 32'(k*8), 64'hF1E2D3C4_B5A69788 + 64'(k), 8'hFF);
    for (int k = 10; k < 14; k++) rd_chk("R4 alpha-first read", FIRST + 32'(k*8));

    // R6 partial strobes
    cfg_mode = 2'b10;
    wr_chk("R6 pixel1 masked", FIRST + 32'(20*8), 64'h1111_1111_2222_2222, 8'h0F);
    wr_chk("R6 pixel0 masked", FIRST + 32'(21*8), 64'h3333_3333_4444_4444, 8'h70);
    wr_chk("R6 alpha only", FIRST + 32'(22*8), 64'h5555_5555_6666_6666, 8'h88);
    wr_chk("R6 sparse", FIRST + 32'(23*8), 64'h7777_7777_8888_8888, 8'h25);
    for (int k = 20; k < 24; k++) rd_chk("R6 readback", FIRST + 32'(k*8));

    // R8 pass-through
    cfg_mode = 2'b00;
    wr_chk("R8 pass write", 32'h180, 64'hDEADBEEF_CAFEF00D, 8'hA5);
    rd_chk("R8 pass read", 32'h180);
    rd_chk("R8 pass read2", 32'h48);
    finish_up();
  end
endmodule